// File: doc/BRIEF.md
# I2C Slave Byte-Addressed Memory

This block is a two-wire serial slave that fronts an on-chip array of 512 bytes. The bus clock and data lines are sampled by a fast system clock through synchronizers and edge detectors. The block recognises bus START and STOP events and decodes a device-select byte. It then takes a word address and moves data through an auto-incrementing address pointer. It pulls the data line low through an open-drain output-enable and never drives it high.

The select byte carries a fixed four-bit device code, then the strap bits, then the page bit, then the direction bit. The page bit is the top bit of the byte address, and the word-address byte that follows supplies the lower eight bits. Writes land in the array as each byte completes, so there is no busy state and nothing to poll. Reads stream successive bytes for as long as the master keeps acknowledging. Two strap inputs let up to four such blocks share one bus, and a protect input stops every write.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0) and the block waits for a START.
- R2: A START is the data line falling while the clock line is high, and a STOP is the data line rising while the clock line is high. After a START, a select byte of 1010 in bits 7:4, the straps in bits 3:2, the page in bit 1 and direction in bit 0 (1 = read) is acknowledged by holding the data line low for the whole 9th clock high time.
- R3: A select byte whose code or strap bits do not match gets no acknowledge. The block then never drives the data line and writes nothing until the next START.
- R4: The byte address is 9 bits. Bit 8 is the page bit of a write select, and bits 7:0 come from the word-address byte that follows it. The word-address byte is acknowledged.
- R5: Every write data byte is acknowledged and stored at the current address once its acknowledge clock ends. The pointer then advances by one, and the next byte may follow at once.
- R6: While `wprot_i` is 1, write data bytes are still acknowledged and still advance the pointer, but the array is left unchanged.
- R7: Read data is sent most significant bit first, with each bit placed after a clock falling edge. The block keeps sending successive bytes while the master acknowledges. A no-acknowledge releases the line and ends the read.
- R8: The address pointer wraps from 0x1FF to 0x000 on both reads and writes.
- R9: A read select that does not follow a word address starts at the current pointer, and its page bit is ignored.
- R10: A START at any point abandons the transfer in progress, drops any partly received byte, releases the line and expects a new select byte.
- R11: A STOP at any point abandons the transfer in progress, drops any partly received byte and releases the line.
- R12: The output enable changes only while the clock line is low, apart from the release that follows a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 2 | Device-select straps, compared with select bits 3:2 |
| wprot_i | input | 1 | 1 blocks every write to the array |

## Verification
The bench builds the block with a three-stage synchronizer and a single page bit. The deeper synchronizer checks that the bit timing still holds when the response lags the bus by an extra cycle. The single page bit gives the 512-byte space, so the pointer wrap and the crossing from page 0 into page 1 take only a few bytes each. The straps are set to a non-zero value, so a select carrying the default 00 is a genuine mismatch and its bytes must be ignored.

// File: rtl/smem_pkg.sv
package smem_pkg;
   localparam int BYTE_W   = 8;
   localparam int ACK_SLOT = 8;
   localparam int END_SLOT = 9;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SEL,
      PH_WADDR,
      PH_WRITE,
      PH_READ
   } phase_t;
endpackage

// File: rtl/smem_line_sync.sv
module smem_line_sync #(
   parameter int STAGES   = 2,
   parameter bit IDLE_VAL = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= {STAGES{IDLE_VAL}};
         prev_q  <= IDLE_VAL;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~prev_q;
   assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/smem_array.sv
module smem_array #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 8,
   localparam int DEPTH = 1 << ADDR_W
)(
   input  logic              clk,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wdata;
   end

   assign rdata = cells[addr];
endmodule

// File: rtl/smem_proto.sv
module smem_proto import smem_pkg::*; #(
   parameter logic [3:0] DEV_CODE = 4'b1010,
   parameter int PAGE_W = 1,
   localparam int STRAP_W = 3 - PAGE_W,
   localparam int ADDR_W  = PAGE_W + BYTE_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               sda_lvl,
   input  logic               start_ev,
   input  logic               stop_ev,
   input  logic [STRAP_W-1:0] strap,
   input  logic               wprot,
   input  logic [BYTE_W-1:0]  rd_data,
   output logic               sda_oe,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               mem_we,
   output logic [BYTE_W-1:0]  wr_data
);
   phase_t             phase_q;
   logic [3:0]         cnt_q;
   logic [BYTE_W-1:0]  rx_q;
   logic [BYTE_W-1:0]  tx_q;
   logic [ADDR_W-1:0]  ptr_q;
   logic [PAGE_W-1:0]  page_q;
   logic               rw_q;
   logic               mack_q;
   logic               oe_q;

   logic sel_ok, ack_fall, end_fall, bus_ev;

   assign sel_ok   = (rx_q[7:4] == DEV_CODE) && (rx_q[3:PAGE_W+1] == strap);
   assign ack_fall = scl_fall && (cnt_q == 4'(ACK_SLOT));
   assign end_fall = scl_fall && (cnt_q == 4'(END_SLOT));
   assign bus_ev   = start_ev | stop_ev;

   assign mem_we   = (phase_q == PH_WRITE) && end_fall && !wprot && !bus_ev;
   assign mem_addr = ptr_q;
   assign wr_data  = rx_q;
   assign sda_oe   = oe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         rx_q    <= '0;
         tx_q    <= '0;
         ptr_q   <= '0;
         page_q  <= '0;
         rw_q    <= 1'b0;
         mack_q  <= 1'b0;
         oe_q    <= 1'b0;
      end else if (start_ev) begin
         phase_q <= PH_SEL;
         cnt_q   <= '0;
         oe_q    <= 1'b0;
      end else if (stop_ev) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         oe_q    <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
         if (scl_rise) begin
            if (cnt_q < 4'(ACK_SLOT)) rx_q <= {rx_q[BYTE_W-2:0], sda_lvl};
            if (cnt_q == 4'(ACK_SLOT)) mack_q <= ~sda_lvl;
            if (cnt_q != 4'(END_SLOT)) cnt_q <= cnt_q + 4'd1;
         end else if (ack_fall) begin
            case (phase_q)
               PH_SEL: begin
                  if (sel_ok) begin
                     oe_q   <= 1'b1;
                     page_q <= rx_q[PAGE_W:1];
                     rw_q   <= rx_q[0];
                  end else begin
                     phase_q <= PH_IDLE;
                     oe_q    <= 1'b0;
                  end
               end
               PH_READ: oe_q <= 1'b0;
               default: oe_q <= 1'b1;
            endcase
         end else if (end_fall) begin
            cnt_q <= '0;
            case (phase_q)
               PH_SEL: begin
                  if (rw_q) begin
                     phase_q <= PH_READ;
                     tx_q    <= {rd_data[BYTE_W-2:0], 1'b0};
                     oe_q    <= ~rd_data[BYTE_W-1];
                     ptr_q   <= ptr_q + 1'b1;
                  end else begin
                     phase_q <= PH_WADDR;
                     oe_q    <= 1'b0;
                  end
               end
               PH_WADDR: begin
                  ptr_q   <= {page_q, rx_q};
                  phase_q <= PH_WRITE;
                  oe_q    <= 1'b0;
               end
               PH_WRITE: begin
                  ptr_q <= ptr_q + 1'b1;
                  oe_q  <= 1'b0;
               end
               PH_READ: begin
                  if (mack_q) begin
                     tx_q  <= {rd_data[BYTE_W-2:0], 1'b0};
                     oe_q  <= ~rd_data[BYTE_W-1];
                     ptr_q <= ptr_q + 1'b1;
                  end else begin
                     phase_q <= PH_IDLE;
                     oe_q    <= 1'b0;
                  end
               end
               default: oe_q <= 1'b0;
            endcase
         end else if (scl_fall && (phase_q == PH_READ) &&
                      (cnt_q != 4'd0) && (cnt_q < 4'(ACK_SLOT))) begin
            oe_q <= ~tx_q[BYTE_W-1];
            tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave import smem_pkg::*; #(
   parameter logic [3:0] DEV_CODE = 4'b1010,
   parameter int PAGE_W = 1,
   parameter int SYNC_STAGES = 2,
   localparam int STRAP_W = 3 - PAGE_W,
   localparam int ADDR_W  = PAGE_W + BYTE_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               wprot_i
);
   if (PAGE_W < 1 || PAGE_W > 2) begin : g_bad_page
      $error("PAGE_W must be 1 or 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   localparam int LINE_SCL = 0;
   localparam int LINE_SDA = 1;

   logic [1:0] line_in, line_lvl, line_rise, line_fall;
   assign line_in = {sda_i, scl_i};

   for (genvar g = 0; g < 2; g++) begin : g_line
      smem_line_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .d_i    (line_in[g]),
         .lvl_o  (line_lvl[g]),
         .rise_o (line_rise[g]),
         .fall_o (line_fall[g])
      );
   end

   logic scl_lvl, start_ev, stop_ev, mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [BYTE_W-1:0] wr_data, rd_data;

   assign scl_lvl  = line_lvl[LINE_SCL];
   assign start_ev = scl_lvl & line_fall[LINE_SDA];
   assign stop_ev  = scl_lvl & line_rise[LINE_SDA];

   smem_proto #(.DEV_CODE(DEV_CODE), .PAGE_W(PAGE_W)) u_proto (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_rise (line_rise[LINE_SCL]),
      .scl_fall (line_fall[LINE_SCL]),
      .sda_lvl  (line_lvl[LINE_SDA]),
      .start_ev (start_ev),
      .stop_ev  (stop_ev),
      .strap    (strap_i),
      .wprot    (wprot_i),
      .rd_data  (rd_data),
      .sda_oe   (sda_oe),
      .mem_addr (mem_addr),
      .mem_we   (mem_we),
      .wr_data  (wr_data)
   );

   smem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_array (
      .clk   (clk),
      .addr  (mem_addr),
      .we    (mem_we),
      .wdata (wr_data),
      .rdata (rd_data)
   );
endmodule

// File: rtl/smem_chk.sv
module smem_chk (
   input logic clk,
   input logic rst_n,
   input logic sda_oe,
   input logic scl_lvl,
   input logic scl_fall,
   input logic start_ev,
   input logic stop_ev,
   input logic mem_we,
   input logic wprot_i
);
   assert_start_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> !sda_oe);

   assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !sda_oe);

   assert_steady_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && $past(scl_lvl) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe));

   assert_change_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev));

   assert_no_protected_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !wprot_i);
endmodule

bind serial_mem_slave smem_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sda_oe   (sda_oe),
   .scl_lvl  (scl_lvl),
   .scl_fall (line_fall[0]),
   .start_ev (start_ev),
   .stop_ev  (stop_ev),
   .mem_we   (mem_we),
   .wprot_i  (wprot_i)
);

// File: tb/serial_mem_slave_tb_top.sv
module serial_mem_slave_tb_top;
   localparam int Q = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic [1:0] straps = 2'b01;
   logic wp = 1'b0;
   logic oe;
   logic sda_line;

   always #10 clk = ~clk;
   assign sda_line = m_sda & ~oe;

   serial_mem_slave #(.PAGE_W(1), .SYNC_STAGES(3)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (m_scl),
      .sda_i   (sda_line),
      .sda_oe  (oe),
      .strap_i (straps),
      .wprot_i (wp)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int mem_m [512];
   int ptr_m = 0;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      end
   endtask

   // one bus clock; compares sda_oe on every system clock of the high phase
   task automatic bit_xfer(input logic b, input logic exp_oe, input string req,
                           output logic got);
      logic seen;
      seen = exp_oe;
      got  = 1'b1;
      repeat (Q) @(posedge clk);
      m_sda <= b;
      repeat (Q) @(posedge clk);
      m_scl <= 1'b1;
      for (int i = 0; i < 2*Q; i++) begin
         @(negedge clk);
         if (oe !== exp_oe) seen = oe;
         if (i == Q) got = sda_line;
      end
      @(posedge clk);
      m_scl <= 1'b0;
      check(req, "drive during clock high", {31'd0, seen}, {31'd0, exp_oe});
   endtask

   task automatic bus_start();
      repeat (Q) @(posedge clk);
      m_sda <= 1'b1;
      repeat (Q) @(posedge clk);
      m_scl <= 1'b1;
      repeat (Q) @(posedge clk);
      m_sda <= 1'b0;
      repeat (Q) @(posedge clk);
      m_scl <= 1'b0;
   endtask

   task automatic bus_stop();
      repeat (Q) @(posedge clk);
      m_sda <= 1'b0;
      repeat (Q) @(posedge clk);
      m_scl <= 1'b1;
      repeat (Q) @(posedge clk);
      m_sda <= 1'b1;
      repeat (2*Q) @(posedge clk);
   endtask

   task automatic byte_w(input logic [7:0] d, input logic exp_ack, input string req);
      logic g;
      for (int i = 7; i >= 0; i--) bit_xfer(d[i], 1'b0, req, g);
      bit_xfer(1'b1, exp_ack, req, g);
      check(req, "acknowledge", {31'd0, ~g}, {31'd0, exp_ack});
   endtask

   task automatic byte_r(input logic [7:0] exp, input logic mack, input string req);
      logic g;
      logic [7:0] v;
      for (int i = 7; i >= 0; i--) begin
         bit_xfer(1'b1, ~exp[i], req, g);
         v[i] = g;
      end
      check(req, "read byte", {24'd0, v}, {24'd0, exp});
      bit_xfer(~mack, 1'b0, req, g);
   endtask

   function automatic logic [7:0] sel_byte(input logic [1:0] s, input logic page, input logic rd);
      return {4'b1010, s, page, rd};
   endfunction

   task automatic wr_seq(input int addr, input int n, input int seed, input string req);
      int a;
      logic [7:0] d;
      a = addr;
      bus_start();
      byte_w(sel_byte(straps, addr[8], 1'b0), 1'b1, "R2");
      byte_w(addr[7:0], 1'b1, "R4");
      for (int k = 0; k < n; k++) begin
         d = 8'((seed + k * 37) & 8'hFF);
         byte_w(d, 1'b1, req);
         if (!wp) mem_m[a] = int'(d);
         a = (a + 1) % 512;
      end
      ptr_m = a;
      bus_stop();
   endtask

   task automatic rd_body(input int n, input string req);
      for (int k = 0; k < n; k++) begin
         byte_r(8'(mem_m[ptr_m]), (k != n - 1), req);
         ptr_m = (ptr_m + 1) % 512;
      end
      bus_stop();
   endtask

   task automatic rd_rand(input int addr, input int n, input string req);
      bus_start();
      byte_w(sel_byte(straps, addr[8], 1'b0), 1'b1, "R2");
      byte_w(addr[7:0], 1'b1, "R4");
      ptr_m = addr;
      bus_start();
      byte_w(sel_byte(straps, addr[8], 1'b1), 1'b1, "R2");
      rd_body(n, req);
   endtask

   task automatic rd_cur(input int n, input logic page, input string req);
      bus_start();
      byte_w(sel_byte(straps, page, 1'b1), 1'b1, "R9");
      rd_body(n, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic g;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check("R1", "output enable in reset", {31'd0, oe}, 32'd0);
      rst_n <= 1'b1;
      repeat (10) @(posedge clk);
      @(negedge clk);
      check("R1", "output enable after reset", {31'd0, oe}, 32'd0);

      // R5 R4: sequential write crossing from page 0 into page 1
      wr_seq(9'h0FE, 4, 8'h11, "R5");
      // R7 R4: random read back, streaming with master acknowledges
      rd_rand(9'h0FE, 2, "R7");
      // R9: current-address read continues at 0x100; page bit 0 ignored
      rd_cur(2, 1'b0, "R9");

      // R8: wrap on write and on read
      wr_seq(9'h1FE, 4, 8'h80, "R8");
      rd_rand(9'h1FF, 3, "R8");

      // R6: protected write acked, discarded, pointer still advances
      wr_seq(9'h010, 3, 8'h21, "R5");
      wp = 1'b1;
      wr_seq(9'h010, 2, 8'hC4, "R6");
      wp = 1'b0;
      rd_cur(1, 1'b1, "R6");
      rd_rand(9'h010, 2, "R6");

      // R3: strap mismatch, then code mismatch; nothing driven or written
      wr_seq(9'h040, 2, 8'h5E, "R5");
      bus_start();
      byte_w(sel_byte(2'b00, 1'b0, 1'b0), 1'b0, "R3");
      byte_w(8'h40, 1'b0, "R3");
      byte_w(8'h99, 1'b0, "R3");
      bus_stop();
      bus_start();
      byte_w({4'b1011, straps, 1'b0, 1'b0}, 1'b0, "R3");
      byte_w(8'h41, 1'b0, "R3");
      byte_w(8'h77, 1'b0, "R3");
      bus_stop();
      rd_rand(9'h040, 2, "R3");

      // R10: START inside a write byte; partial byte dropped, select accepted
      wr_seq(9'h020, 2, 8'h33, "R5");
      bus_start();
      byte_w(sel_byte(straps, 1'b0, 1'b0), 1'b1, "R2");
      byte_w(8'h20, 1'b1, "R4");
      byte_w(8'h5A, 1'b1, "R5");
      mem_m[9'h020] = 8'h5A;
      ptr_m = 9'h021;
      for (int i = 7; i >= 4; i--) bit_xfer(i[0], 1'b0, "R10", g);
      bus_start();
      byte_w(sel_byte(straps, 1'b0, 1'b1), 1'b1, "R10");
      rd_body(1, "R10");
      rd_rand(9'h020, 2, "R10");

      // R11: STOP inside a write byte; partial byte dropped
      wr_seq(9'h030, 2, 8'h6B, "R5");
      bus_start();
      byte_w(sel_byte(straps, 1'b0, 1'b0), 1'b1, "R2");
      byte_w(8'h30, 1'b1, "R4");
      ptr_m = 9'h030;
      for (int i = 7; i >= 4; i--) bit_xfer(~i[0], 1'b0, "R11", g);
      bus_stop();
      @(negedge clk);
      check("R11", "released after stop", {31'd0, oe}, 32'd0);
      rd_cur(2, 1'b0, "R11");

      // R2: other strap setting selects the device
      straps = 2'b10;
      wr_seq(9'h150, 3, 8'hA7, "R5");
      rd_rand(9'h150, 3, "R2");
      @(negedge clk);
      check("R7", "released after read", {31'd0, oe}, 32'd0);

      summary();
      $finish;
   end
endmodule